// File: doc/BRIEF.md
# ATA Device Probe and Identify Sequencer

This block is a host-side controller that checks whether a disk device sits at one of four positions (two interfaces, each with a master and a slave) and, if one answers, fetches its 256-word identification block. It drives a simple register-bus master port, the same kind used by the sector read sequencer, and from the identification data it extracts the 28-bit-addressing and 48-bit-addressing sector counts. It returns a present flag, a flag that says whether the drive supports logical block addressing, and both capacity values.

A probe begins with a pulse on `start` together with a two-bit position index. Bit 1 of the index picks the interface, and the controller presents it on `bus_iface` for the whole probe. Bit 0 picks master (0) or slave (1). The controller first checks for a floating bus, waits for the interface to go quiet, selects the device and lets it settle, and then sends the identify command. It follows this by polling busy and data-request status, each poll loop with its own timeout. The capacity words are taken as they stream past, so no block buffer is needed. A one-cycle `done` pulse marks the end of the probe, and all results stay stable until the next probe is accepted.

Top module: `ata_probe`

## Requirements
- R1: Bus accesses are one at a time. `bus_req` stays high, with `bus_we`, `bus_addr` and `bus_wdata` stable, until the cycle in which `bus_ack` is seen. Address codes: 4'hE alternate status, 4'h6 device select, 4'h7 command, 4'h0 data.
- R2: `start` is taken only when the block is idle and is ignored while a probe runs. `dev_index[1]` appears on `bus_iface`; `dev_index[0]` is the master/slave id.
- R3: If the first alternate-status read returns 8'hFF, the probe ends as absent with no bus write issued.
- R4: Before selecting, status is polled until BSY (bit 7) and DRQ (bit 3) are both clear. The device-select register is then written with the id in bit 4 (master 16'h0000, slave 16'h0010). At least SETTLE_CYC idle cycles follow, and then the command register is written with 16'h00EC.
- R5: If the status read right after the command is 8'h00, or has ERR (bit 0) set, the probe ends as absent.
- R6: Status is re-read while BSY is set and ERR is clear. An ERR seen in this loop ends the probe as absent.
- R7: After BSY clears, status is polled until DRQ is set. Exactly WORDS data reads follow, and a probe that ends early performs none.
- R8: `cap28` equals identify word 61 (high half) concatenated with word 60 (low half).
- R9: `cap48` equals words 102, 101 and 100, with word 100 least significant. Word 103 has no effect.
- R10: A zero `cap28` gives `present`=1 and `lba_ok`=0. An absent probe always gives `lba_ok`=0.
- R11: Each polling loop gives up and ends as absent after POLL_LIMIT consecutive reads that do not meet its exit condition. POLL_LIMIT-1 such reads followed by a passing read continue the probe.
- R12: `done` is a single-cycle pulse. `present`, `lba_ok`, `cap28` and `cap48` hold their values after `done` and are cleared in the cycle after a `start` is accepted.
- R13: After reset, `done`, `present`, `lba_ok`, `cap28`, `cap48` and `bus_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (taken only when idle) |
| dev_index | input | 2 | Position: bit 1 interface, bit 0 master/slave |
| done | output | 1 | One-cycle completion pulse |
| present | output | 1 | A device answered the identify command |
| lba_ok | output | 1 | The device reports a nonzero 28-bit sector count |
| cap28 | output | C28_W | 28-bit-addressing sector count |
| cap48 | output | C48_W | 48-bit-addressing sector count |
| bus_iface | output | 1 | Interface addressed by the current probe |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Register code of the access |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | DW | Read data |

## Verification
The hardest situations to reach from the ports are the poll-loop edges: an ERR that shows up only after several busy reads, and a busy or not-ready phase that lasts exactly POLL_LIMIT-1 or exactly POLL_LIMIT reads. The bench uses a scripted device model that counts the status reads after the command and returns busy, ERR, not-ready or ready at chosen read numbers. This lets each loop be pushed to one read either side of its limit. The same model fills the identification block with a known pattern and places an all-ones word 103 next to the capacity words, so a capture slip or a missing mask shows up in the captured values.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;

  // register codes seen on the bus: bit 3 selects the control block
  localparam logic [3:0] RC_DATA   = 4'h0;
  localparam logic [3:0] RC_DEVSEL = 4'h6;
  localparam logic [3:0] RC_CMD    = 4'h7;
  localparam logic [3:0] RC_ALTST  = 4'hE;

  localparam logic [7:0] OP_IDENT  = 8'hEC;
  localparam logic [7:0] ST_FLOAT  = 8'hFF;

  // status bit positions
  localparam int SB_ERR = 0;
  localparam int SB_DRQ = 3;
  localparam int SB_BSY = 7;

  typedef enum logic [3:0] {
    PS_IDLE,
    PS_FLOAT,
    PS_SELWAIT,
    PS_SELWR,
    PS_SETTLE,
    PS_CMDWR,
    PS_CMDCHK,
    PS_BSYPOLL,
    PS_DRQPOLL,
    PS_XFER,
    PS_FINISH
  } probe_st_e;

endpackage

// File: rtl/ata_bus_port.sv
module ata_bus_port #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          op_done,
  output logic [DW-1:0] op_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      op_done   <= 1'b0;
      op_rdata  <= '0;
    end else begin
      op_done <= 1'b0;
      if (bus_req && bus_ack) begin
        bus_req  <= 1'b0;
        op_done  <= 1'b1;
        op_rdata <= bus_rdata;
      end else if (go && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_wdata;
      end
    end
  end

endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic miss,
  output logic expire
);

  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] miss_cnt_q;

  // the miss that would make POLL_LIMIT in a row ends the loop
  assign expire = miss && (miss_cnt_q == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      miss_cnt_q <= '0;
    end else if (miss && !expire) begin
      miss_cnt_q <= miss_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ata_ident_capture.sv
module ata_ident_capture #(
  parameter int DW      = 16,
  parameter int WORDS   = 256,
  parameter int W28_POS = 60,
  parameter int W48_POS = 100,
  parameter int C28_W   = 32,
  parameter int C48_W   = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wvalid,
  input  logic [DW-1:0]    wdata,
  output logic             last,
  output logic [C28_W-1:0] cap28,
  output logic [C48_W-1:0] cap48
);

  localparam int IW  = $clog2(WORDS);
  localparam int N28 = C28_W / DW;
  localparam int N48 = C48_W / DW;

  logic [IW-1:0] idx_q;

  assign last = wvalid && (idx_q == IW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q <= '0;
    end else if (wvalid) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // one capture register per word of each count, picked by stream position
  for (genvar k = 0; k < N28; k++) begin : g_c28
    logic [DW-1:0] seg_q;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        seg_q <= '0;
      end else if (wvalid && (idx_q == IW'(W28_POS + k))) begin
        seg_q <= wdata;
      end
    end
    assign cap28[DW*k +: DW] = seg_q;
  end

  for (genvar k = 0; k < N48; k++) begin : g_c48
    logic [DW-1:0] seg_q;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        seg_q <= '0;
      end else if (wvalid && (idx_q == IW'(W48_POS + k))) begin
        seg_q <= wdata;
      end
    end
    assign cap48[DW*k +: DW] = seg_q;
  end

endmodule

// File: rtl/ata_probe.sv
module ata_probe
  import ata_probe_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter int WORDS      = 256,
  parameter int POLL_LIMIT = 1000,
  parameter int SETTLE_CYC = 4,
  parameter int W28_POS    = 60,
  parameter int W48_POS    = 100,
  parameter int C28_W      = 32,
  parameter int C48_W      = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       dev_index,
  output logic             done,
  output logic             present,
  output logic             lba_ok,
  output logic [C28_W-1:0] cap28,
  output logic [C48_W-1:0] cap48,
  output logic             bus_iface,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ack,
  input  logic [DW-1:0]    bus_rdata
);

  localparam int SW = $clog2(SETTLE_CYC + 1);

  probe_st_e     state_q;
  logic          launched_q;
  logic          id_q;
  logic          iface_q;
  logic          fin_p_q;
  logic [SW-1:0] settle_q;

  logic          go, go_we;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] go_wdata;
  logic          op_done;
  logic [DW-1:0] op_rdata;
  logic [7:0]    st;
  logic          on_bus;
  logic          start_acc;
  logic          tmr_miss, tmr_clr, tmr_exp;
  logic          cap_last;

  assign st        = op_rdata[7:0];
  assign start_acc = start && (state_q == PS_IDLE);
  assign bus_iface = iface_q;

  // ---------------- request generation ----------------
  always_comb begin
    on_bus = 1'b0;
    unique case (state_q)
      PS_FLOAT, PS_SELWAIT, PS_SELWR, PS_CMDWR,
      PS_CMDCHK, PS_BSYPOLL, PS_DRQPOLL, PS_XFER: on_bus = 1'b1;
      default: on_bus = 1'b0;
    endcase
  end

  assign go    = on_bus && !launched_q;
  assign go_we = (state_q == PS_SELWR) || (state_q == PS_CMDWR);

  always_comb begin
    go_addr  = AW'(RC_ALTST);
    go_wdata = '0;
    unique case (state_q)
      PS_SELWR: begin
        go_addr  = AW'(RC_DEVSEL);
        go_wdata = DW'({id_q, 4'b0000});
      end
      PS_CMDWR: begin
        go_addr  = AW'(RC_CMD);
        go_wdata = DW'(OP_IDENT);
      end
      PS_XFER:  go_addr = AW'(RC_DATA);
      default:  go_addr = AW'(RC_ALTST);
    endcase
  end

  // a status read that does not meet its loop's exit condition
  always_comb begin
    unique case (state_q)
      PS_SELWAIT: tmr_miss = op_done && (st[SB_BSY] || st[SB_DRQ]);
      PS_BSYPOLL: tmr_miss = op_done && !st[SB_ERR] && st[SB_BSY];
      PS_DRQPOLL: tmr_miss = op_done && !st[SB_ERR] && !st[SB_DRQ];
      default:    tmr_miss = 1'b0;
    endcase
  end

  assign tmr_clr = op_done && !tmr_miss;

  // ---------------- sub-blocks ----------------
  ata_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_we    (go_we),
    .go_addr  (go_addr),
    .go_wdata (go_wdata),
    .op_done  (op_done),
    .op_rdata (op_rdata),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata)
  );

  ata_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clr),
    .miss  (tmr_miss),
    .expire(tmr_exp)
  );

  ata_ident_capture #(
    .DW(DW), .WORDS(WORDS), .W28_POS(W28_POS), .W48_POS(W48_POS),
    .C28_W(C28_W), .C48_W(C48_W)
  ) u_cap (
    .clk   (clk),
    .rst   (rst),
    .clear (start_acc),
    .wvalid(op_done && (state_q == PS_XFER)),
    .wdata (op_rdata),
    .last  (cap_last),
    .cap28 (cap28),
    .cap48 (cap48)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PS_IDLE;
      launched_q <= 1'b0;
      id_q       <= 1'b0;
      iface_q    <= 1'b0;
      fin_p_q    <= 1'b0;
      settle_q   <= '0;
      done       <= 1'b0;
      present    <= 1'b0;
      lba_ok     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go)      launched_q <= 1'b1;
      if (op_done) launched_q <= 1'b0;

      unique case (state_q)
        PS_IDLE: begin
          if (start) begin
            id_q    <= dev_index[0];
            iface_q <= dev_index[1];
            present <= 1'b0;
            lba_ok  <= 1'b0;
            state_q <= PS_FLOAT;
          end
        end
        PS_FLOAT: begin
          if (op_done) begin
            if (st == ST_FLOAT) begin
              fin_p_q <= 1'b0;
              state_q <= PS_FINISH;
            end else begin
              state_q <= PS_SELWAIT;
            end
          end
        end
        PS_SELWAIT: begin
          if (op_done) begin
            if (tmr_miss) begin
              if (tmr_exp) begin
                fin_p_q <= 1'b0;
                state_q <= PS_FINISH;
              end
            end else begin
              state_q <= PS_SELWR;
            end
          end
        end
        PS_SELWR: begin
          if (op_done) begin
            settle_q <= '0;
            state_q  <= PS_SETTLE;
          end
        end
        PS_SETTLE: begin
          if (settle_q == SW'(SETTLE_CYC - 1)) begin
            state_q <= PS_CMDWR;
          end else begin
            settle_q <= settle_q + 1'b1;
          end
        end
        PS_CMDWR: begin
          if (op_done) state_q <= PS_CMDCHK;
        end
        PS_CMDCHK: begin
          if (op_done) begin
            if ((st == 8'h00) || st[SB_ERR]) begin
              fin_p_q <= 1'b0;
              state_q <= PS_FINISH;
            end else begin
              state_q <= PS_BSYPOLL;
            end
          end
        end
        PS_BSYPOLL: begin
          if (op_done) begin
            if (st[SB_ERR]) begin
              fin_p_q <= 1'b0;
              state_q <= PS_FINISH;
            end else if (tmr_miss) begin
              if (tmr_exp) begin
                fin_p_q <= 1'b0;
                state_q <= PS_FINISH;
              end
            end else begin
              state_q <= PS_DRQPOLL;
            end
          end
        end
        PS_DRQPOLL: begin
          if (op_done) begin
            if (st[SB_ERR]) begin
              fin_p_q <= 1'b0;
              state_q <= PS_FINISH;
            end else if (tmr_miss) begin
              if (tmr_exp) begin
                fin_p_q <= 1'b0;
                state_q <= PS_FINISH;
              end
            end else begin
              state_q <= PS_XFER;
            end
          end
        end
        PS_XFER: begin
          if (cap_last) begin
            fin_p_q <= 1'b1;
            state_q <= PS_FINISH;
          end
        end
        PS_FINISH: begin
          done    <= 1'b1;
          present <= fin_p_q;
          lba_ok  <= fin_p_q && (cap28 != '0);
          state_q <= PS_IDLE;
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ata_probe_chk.sv
module ata_probe_chk #(
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int C28_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_ack,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             done,
  input logic             present,
  input logic             lba_ok,
  input logic [C28_W-1:0] cap28
);

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req);

  // R1
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  absent_nolba_chk: assert property (@(posedge clk) disable iff (rst)
    done && !present |-> !lba_ok);

  // R10
  lba_cap_chk: assert property (@(posedge clk) disable iff (rst)
    done && lba_ok |-> (cap28 != '0));

  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req);

endmodule

bind ata_probe ata_probe_chk #(.AW(AW), .DW(DW), .C28_W(C28_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .done     (done),
  .present  (present),
  .lba_ok   (lba_ok),
  .cap28    (cap28)
);

// File: tb/ata_probe_test.sv
`timescale 1ns/1ps
module ata_probe_test;

  localparam int LIM = 8;
  localparam int SET = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  dev_index = 2'd0;
  logic        done, present, lba_ok, bus_iface, bus_req, bus_we;
  logic [31:0] cap28;
  logic [47:0] cap48;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  always #10 clk = ~clk;   // 50 MHz

  ata_probe #(.POLL_LIMIT(LIM), .SETTLE_CYC(SET)) uut (
    .clk(clk), .rst(rst), .start(start), .dev_index(dev_index),
    .done(done), .present(present), .lba_ok(lba_ok),
    .cap28(cap28), .cap48(cap48), .bus_iface(bus_iface),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int total = 0;
  int bad = 0;
  int n_done = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- scripted device model ----------------
  bit          m_float, m_cmd_zero, m_cmd_err, m_busy_err;
  int          m_sel_busy, m_busy_n, m_drq_n;
  logic [31:0] m_c28;
  logic [47:0] m_c48;
  int          sel_cnt, post_cnt, data_reads, wr_count, cyc;
  bit          cmd_seen;
  logic [15:0] devreg_val, cmd_val;
  int          devreg_cyc, cmd_cyc;

  function automatic logic [15:0] word_of(input int i);
    case (i)
      60:  return m_c28[15:0];
      61:  return m_c28[31:16];
      100: return m_c48[15:0];
      101: return m_c48[31:16];
      102: return m_c48[47:32];
      103: return 16'hFFFF;
      default: return 16'(i * 3 + 7);
    endcase
  endfunction

  function automatic logic [7:0] status_of();
    logic [7:0] s;
    if (!cmd_seen) begin
      if (m_float) s = 8'hFF;
      else if (sel_cnt < m_sel_busy) begin s = 8'h88; sel_cnt++; end
      else s = 8'h50;
    end else begin
      if (m_cmd_zero) s = 8'h00;
      else if (m_cmd_err) s = 8'h41;
      else if (post_cnt < m_busy_n + 1) s = 8'hD0;
      else if (m_busy_err) s = 8'h41;
      else if (post_cnt < m_busy_n + 1 + m_drq_n) s = 8'h50;
      else s = 8'h58;
      post_cnt++;
    end
    return s;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        wr_count++;
        if (bus_addr == 4'h6) begin devreg_val = bus_wdata; devreg_cyc = cyc; end
        if (bus_addr == 4'h7) begin cmd_val = bus_wdata; cmd_cyc = cyc; cmd_seen = 1; end
      end else if (bus_addr == 4'hE) begin
        bus_rdata <= {8'h00, status_of()};
      end else if (bus_addr == 4'h0) begin
        bus_rdata <= word_of(data_reads);
        data_reads++;
      end else begin
        bus_rdata <= 16'h0000;
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic model_cfg(input bit fl, input int selb, input bit cz, input bit ce,
                           input int bn, input bit be, input int dn,
                           input logic [31:0] c28, input logic [47:0] c48);
    m_float = fl; m_sel_busy = selb; m_cmd_zero = cz; m_cmd_err = ce;
    m_busy_n = bn; m_busy_err = be; m_drq_n = dn; m_c28 = c28; m_c48 = c48;
    sel_cnt = 0; post_cnt = 0; data_reads = 0; wr_count = 0; cmd_seen = 0;
    devreg_val = 16'hDEAD; cmd_val = 16'hDEAD; devreg_cyc = 0; cmd_cyc = 0;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic        p;
    logic        l;
    logic [31:0] c28;
    logic [47:0] c48;
    logic        ifc;
    logic [15:0] reads;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  mon_e;
  string mon_t;

  function automatic exp_t mk(input logic p, input logic l, input logic [31:0] c28,
                              input logic [47:0] c48, input logic ifc, input int reads);
    exp_t e;
    e.p = p; e.l = l; e.c28 = c28; e.c48 = c48; e.ifc = ifc; e.reads = 16'(reads);
    return e;
  endfunction

  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        chk("R2", "unexpected done", 1, 0);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk(mon_t, "present", present, mon_e.p);
        chk(mon_t, "lba_ok", lba_ok, mon_e.l);
        chk("R8", "cap28", cap28, mon_e.c28);
        chk("R9", "cap48", cap48, mon_e.c48);
        chk("R2", "bus_iface", bus_iface, mon_e.ifc);
        chk("R7", "data reads", data_reads, mon_e.reads);
      end
      n_done++;
    end
  end

  task automatic launch(input logic [1:0] idx, input exp_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    start = 1'b1;
    dev_index = idx;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [1:0] idx, input exp_t e, input string t, input bit chk_clear);
    int nd;
    nd = n_done;
    launch(idx, e, t);
    if (chk_clear) begin
      chk("R12", "present cleared at start", present, 0);
      chk("R12", "cap28 cleared at start", cap28, 0);
      chk("R12", "cap48 cleared at start", cap48, 0);
    end
    while (n_done == nd) @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic        h_p, h_l;
    logic [31:0] h28;
    logic [47:0] h48;
    int          nd;

    model_cfg(0, 0, 0, 0, 0, 0, 0, 32'h0, 48'h0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    chk("R13", "done", done, 0);
    chk("R13", "present", present, 0);
    chk("R13", "lba_ok", lba_ok, 0);
    chk("R13", "cap28", cap28, 0);
    chk("R13", "cap48", cap48, 0);
    chk("R13", "bus_req", bus_req, 0);

    // normal master on interface 0
    model_cfg(0, 0, 0, 0, 1, 0, 1, 32'h0A1B_2C3D, 48'h0000_1234_5678);
    run(2'd0, mk(1, 1, 32'h0A1B_2C3D, 48'h0000_1234_5678, 0, 256), "R8", 0);
    chk("R4", "master select value", devreg_val, 16'h0000);
    chk("R4", "command value", cmd_val, 16'h00EC);
    chk("R4", "settle gap ok", (cmd_cyc - devreg_cyc) > SET, 1);

    // slave on interface 1 with busy select, busy and not-ready phases
    model_cfg(0, 3, 0, 0, 2, 0, 2, 32'h7FFF_0001, 48'hFEDC_BA98_7654);
    run(2'd3, mk(1, 1, 32'h7FFF_0001, 48'hFEDC_BA98_7654, 1, 256), "R9", 0);
    chk("R4", "slave select value", devreg_val, 16'h0010);
    chk("R7", "command before data", cmd_seen, 1);

    // R3 floating bus
    model_cfg(1, 0, 0, 0, 0, 0, 0, 32'h1111_1111, 48'h1);
    run(2'd1, mk(0, 0, 0, 0, 0, 0), "R3", 0);
    chk("R3", "bus writes on float", wr_count, 0);

    // R5 zero status and ERR after command
    model_cfg(0, 0, 1, 0, 0, 0, 0, 32'h5, 48'h5);
    run(2'd2, mk(0, 0, 0, 0, 1, 0), "R5", 0);
    model_cfg(0, 0, 0, 1, 0, 0, 0, 32'h5, 48'h5);
    run(2'd2, mk(0, 0, 0, 0, 1, 0), "R5", 0);

    // R6 ERR appearing after several busy reads
    model_cfg(0, 0, 0, 0, 4, 1, 0, 32'h5, 48'h5);
    run(2'd0, mk(0, 0, 0, 0, 0, 0), "R6", 0);

    // R11 busy loop limits, not-ready timeout, select timeout
    model_cfg(0, 0, 0, 0, LIM - 1, 0, 0, 32'h0000_0100, 48'h200);
    run(2'd0, mk(1, 1, 32'h0000_0100, 48'h200, 0, 256), "R11", 0);
    model_cfg(0, 0, 0, 0, LIM, 0, 0, 32'h0000_0100, 48'h200);
    run(2'd0, mk(0, 0, 0, 0, 0, 0), "R11", 0);
    model_cfg(0, 0, 0, 0, 0, 0, 100, 32'h0000_0100, 48'h200);
    run(2'd1, mk(0, 0, 0, 0, 0, 0), "R11", 0);
    model_cfg(0, 100, 0, 0, 0, 0, 0, 32'h0000_0100, 48'h200);
    run(2'd1, mk(0, 0, 0, 0, 0, 0), "R11", 0);
    chk("R11", "no command after select timeout", cmd_seen, 0);

    // R10 zero 28-bit count
    model_cfg(0, 0, 0, 0, 0, 0, 0, 32'h0, 48'h0000_0000_9999);
    run(2'd2, mk(1, 0, 32'h0, 48'h0000_0000_9999, 1, 256), "R10", 0);

    // R12 hold after done, clear at next start
    h_p = present; h_l = lba_ok; h28 = cap28; h48 = cap48;
    repeat (40) @(negedge clk);
    chk("R12", "present held", present, h_p);
    chk("R12", "lba_ok held", lba_ok, h_l);
    chk("R12", "cap48 held", cap48, h48);
    chk("R12", "cap28 held", cap28, h28);
    model_cfg(0, 0, 0, 0, 0, 0, 0, 32'h0000_4000, 48'h8000);
    run(2'd0, mk(1, 1, 32'h0000_4000, 48'h8000, 0, 256), "R12", 1);

    // R2 start during a probe is ignored
    model_cfg(0, 0, 0, 0, 1, 0, 1, 32'h0000_0042, 48'h43);
    nd = n_done;
    launch(2'd0, mk(1, 1, 32'h0000_0042, 48'h43, 0, 256), "R2");
    repeat (30) @(negedge clk);
    start = 1'b1; dev_index = 2'd3;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "iface kept during probe", bus_iface, 0);
    while (n_done == nd) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R2", "single done", n_done - nd, 1);
    chk("R2", "master kept", devreg_val, 16'h0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule